// File: doc/BRIEF.md
# Gated Multi-Channel Timestamp Packetizer

The block watches eight asynchronous event lines and a gate line. While the gate is open it notes every rising edge on the event lines and stamps it with the number of ticks counted since the gate opened. A tick is one clock cycle with `tick_en` high, so an external divider sets the time resolution. Each gate period turns into a packet of words on a FIFO write port. The packet holds a start word, then one word for each tick period that had edges, then an end word.

A word carries a channel mask in its upper byte and the tick count below it. Edges on several channels inside the same tick period share one word. When the tick counter wraps, an in-band overflow word marks the wrap. Two configuration bits can suppress the start word and the end word. The block does not buffer for the downstream FIFO. It drives a write strobe and data, and it drops a word when the FIFO reports full. A sticky error flag records any dropped word.

Top module: `gated_stamp_packer`

## Requirements
- R1: A word is 32 bits. Bit 24+i is the mask bit for channel i (i = 0..7), and bits 23..0 hold the tick count. The count is cleared when the gate opens and advances by exactly one on each clock with `tick_en` high. Edges seen during a tick period are stamped with the count reached by the tick that closes that period, so the first tick after opening gives stamp 1.
- R2: When the gate opens, the block writes a start word 0x00000000, unless `cfg[1]` is 1.
- R3: All rising edges inside one tick period, on any channels and in any cycles, merge into one word with their mask bits set. For example, channels 0 and 1 give mask 0x03. A tick period with no rising edge writes nothing, and falling edges write nothing.
- R4: Edges count only while the synchronized gate is high and a packet is open. Edges before the gate opens, or after it falls, write no event word.
- R5: When a tick takes the counter from all ones to zero, the block writes an overflow word with mask 0x00 and all-ones timestamp (0x00FFFFFF). An event word from that same tick follows it and carries timestamp 0.
- R6: After the gate falls, the next tick ends the packet. Edges still pending from the last period are written first with that tick's count. Then an end word with mask 0x00 and that count is written, unless `cfg[0]` is 1.
- R7: An end word never carries timestamp 0. If the closing tick wraps the counter to 0, the end word waits for the following tick and carries timestamp 1.
- R8: If `fifo_full` is high when a word leaves, that word is dropped and `fifo_wr` stays low. `drop_err` then goes high and stays high until reset.
- R9: During and right after reset, `fifo_wr` and `drop_err` are low and no packet is open.
- R10: The block writes at most one word per clock. Words leave in the order they were formed: start, overflow before event, event before end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle tick strobe that advances the timestamp counter |
| gate_in | input | 1 | Asynchronous gate level; high opens a packet |
| ch_in | input | 8 | Asynchronous event lines, bit i is channel i |
| cfg | input | 2 | Bit 0 suppresses the end word, bit 1 suppresses the start word |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | Write strobe toward the FIFO |
| fifo_data | output | 32 | Word written with the strobe |
| drop_err | output | 1 | Sticky flag: at least one word was dropped |

## Verification
The bench drives edges on channels 2 and 7 in different cycles of one tick period. A design that stamped edges per cycle instead of per tick would write two words there. A wrap test uses a second instance with a narrow counter. It checks that the overflow word comes ahead of a same-tick event stamped 0, and that an end word falling on a wrap is deferred to stamp 1. A design with the wrong order, or with a zero end stamp, breaks the expected word list. Other tests put edges outside the gate and inside the closing window, and close the gate while an edge is pending. They also run a packet against a full FIFO and check that the error flag survives until reset.

// File: rtl/stamp_pkg.sv
// Package: shared state encoding and configuration bit positions for the
// gated timestamp packetizer. Assumes nothing beyond IEEE 1800-2017.
package stamp_pkg;

    // Packet sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_CLOSE = 2'd2
    } seq_state_t;

    // Positions of the configuration bits on the cfg port
    localparam int CFG_NO_END   = 0;
    localparam int CFG_NO_START = 1;
    localparam int CFG_W        = 2;

    // Number of candidate words the sequencer can form in one cycle
    localparam int CAND_N = 4;

endpackage

// File: rtl/bit_sync.sv
// Module: two-flop synchronizer for W independent single-bit signals.
// Assumes each input bit stays stable for at least two clocks per level.
module bit_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two sampling stages toward the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/edge_catch.sv
// Module: per-channel synchronizer plus one delayed copy. Flags a rising edge
// when the synchronized sample is high and the previous one was low.
// Assumes event pulses last at least two clocks high and two clocks low.
module edge_catch #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_async,
    output logic [NUM_CH-1:0] rise
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            logic cur_s;
            logic prev_s;

            bit_sync #(.W(1)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (ch_async[gi]),
                .q_sync  (cur_s)
            );

            // Delayed copy of the synchronized level for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) prev_s <= 1'b0;
                else        prev_s <= cur_s;
            end

            assign rise[gi] = cur_s & ~prev_s;
        end
    endgenerate

endmodule

// File: rtl/stamp_sequencer.sv
// Module: packet sequencer. Holds the tick counter and the pending channel
// mask and forms up to two words per clock: start, overflow, event and end
// words, in that priority. Assumes tick_en is a synchronous one-cycle strobe
// and that cfg is quasi-static while a packet is open.
module stamp_sequencer
    import stamp_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int TS_W   = 24,
    localparam int WORD_W = NUM_CH + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              gate_lvl,
    input  logic [NUM_CH-1:0] rise,
    input  logic              no_start,
    input  logic              no_end,
    output logic [1:0]        push_n,
    output logic [WORD_W-1:0] push_w0,
    output logic [WORD_W-1:0] push_w1
);

    localparam logic [TS_W-1:0]   TS_ONES  = {TS_W{1'b1}};
    localparam logic [WORD_W-1:0] W_START  = '0;
    localparam logic [WORD_W-1:0] W_OVF    = {{NUM_CH{1'b0}}, TS_ONES};

    seq_state_t        state_q, state_d;
    logic [TS_W-1:0]   cnt_q, cnt_d;
    logic [NUM_CH-1:0] pend_q, pend_d;

    logic [TS_W-1:0]   cnt_inc;
    logic              wrap;
    logic [NUM_CH-1:0] mask_now;
    logic [CAND_N-1:0] cand_v;
    logic [WORD_W-1:0] cand_w [CAND_N];

    assign cnt_inc  = cnt_q + TS_W'(1);
    assign wrap     = (cnt_q == TS_ONES);
    assign mask_now = pend_q | (gate_lvl ? rise : '0);

    // Next-state, counter, pending mask and candidate words
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pend_d  = pend_q;
        cand_v  = '0;
        for (int k = 0; k < CAND_N; k++) cand_w[k] = '0;
        unique case (state_q)
            ST_IDLE: begin
                pend_d = '0;
                if (gate_lvl) begin
                    state_d   = ST_OPEN;
                    cnt_d     = '0;
                    pend_d    = rise;
                    cand_v[0] = !no_start;
                    cand_w[0] = W_START;
                end
            end
            ST_OPEN: begin
                pend_d = mask_now;
                if (tick_en) begin
                    cnt_d     = cnt_inc;
                    pend_d    = '0;
                    cand_v[1] = wrap;
                    cand_w[1] = W_OVF;
                    cand_v[2] = (mask_now != '0);
                    cand_w[2] = {mask_now, cnt_inc};
                end
                if (!gate_lvl) state_d = ST_CLOSE;
            end
            ST_CLOSE: begin
                if (tick_en) begin
                    cnt_d     = cnt_inc;
                    pend_d    = '0;
                    cand_v[1] = wrap;
                    cand_w[1] = W_OVF;
                    cand_v[2] = (pend_q != '0);
                    cand_w[2] = {pend_q, cnt_inc};
                    cand_v[3] = !wrap && !no_end;
                    cand_w[3] = {{NUM_CH{1'b0}}, cnt_inc};
                    if (!wrap || no_end) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pack the valid candidates into at most two ordered push slots
    always_comb begin
        push_n  = 2'd0;
        push_w0 = '0;
        push_w1 = '0;
        for (int k = 0; k < CAND_N; k++) begin
            if (cand_v[k]) begin
                if (push_n == 2'd0) push_w0 = cand_w[k];
                else                push_w1 = cand_w[k];
                push_n = push_n + 2'd1;
            end
        end
    end

    // State, counter and pending mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pend_q  <= pend_d;
        end
    end

    // R1: without a tick, an open or closing packet keeps its count
    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !tick_en) |=> $stable(cnt_q));

    // R5: a tick at all ones brings the counter back to zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && tick_en && cnt_q == TS_ONES) |=> (cnt_q == '0));

    // R4: while closing, new edges never reach the pending mask
    a_r4_close_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSE && !tick_en) |=> $stable(pend_q));

    // R7: a closing tick that wraps keeps the packet open for one more tick
    a_r7_end_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSE && tick_en && cnt_q == TS_ONES && !no_end)
        |=> (state_q == ST_CLOSE && cnt_q == '0));

endmodule

// File: rtl/word_queue.sv
// Module: small staging queue between the sequencer and the FIFO port.
// Takes up to two ordered words per clock and hands out one per clock.
// A word that meets fifo_full, or finds no room, is dropped and the sticky
// error flag is set. Assumes DEPTH is a power of two and at least 2.
module word_queue #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        push_n,
    input  logic [WORD_W-1:0] push_w0,
    input  logic [WORD_W-1:0] push_w1,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              drop_err
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr, wr_ptr;
    logic [CW-1:0]     cnt_q;
    logic              pop;
    logic [CW:0]       free_w;
    logic              acc0, acc1, lost;
    logic [CW-1:0]     n_acc;
    logic              wr_q, err_q;
    logic [WORD_W-1:0] data_q;

    assign pop    = (cnt_q != '0);
    assign free_w = (CW+1)'(DEPTH) - {1'b0, cnt_q} + {{CW{1'b0}}, pop};
    assign acc0   = (push_n != 2'd0) && (free_w >= (CW+1)'(1));
    assign acc1   = (push_n == 2'd2) && (free_w >= (CW+1)'(2));
    assign lost   = ((push_n != 2'd0) && !acc0) || ((push_n == 2'd2) && !acc1);
    assign n_acc  = CW'(acc0) + CW'(acc1);

    // Storage writes for accepted words
    always_ff @(posedge clk) begin
        if (acc0) mem[wr_ptr]            <= push_w0;
        if (acc1) mem[wr_ptr + AW'(1)]   <= push_w1;
    end

    // Pointers, occupancy, output register and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
            wr_q   <= 1'b0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + AW'(n_acc);
            rd_ptr <= rd_ptr + AW'(pop);
            cnt_q  <= cnt_q - CW'(pop) + n_acc;
            wr_q   <= pop && !fifo_full;
            if (pop && !fifo_full) data_q <= mem[rd_ptr];
            err_q  <= err_q || lost || (pop && fifo_full);
        end
    end

    assign fifo_wr   = wr_q;
    assign fifo_data = data_q;
    assign drop_err  = err_q;

    // R10: occupancy never exceeds the storage
    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R8: once set, the error flag holds until reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/gated_stamp_packer.sv
// Module: top of the gated timestamp packetizer. Synchronizes the gate and
// the event lines, runs the packet sequencer and stages its words toward a
// FIFO write port. Assumes tick_en and fifo_full are in the clk domain.
module gated_stamp_packer
    import stamp_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int TS_W   = 24,
    parameter int QDEPTH = 4,
    localparam int WORD_W = NUM_CH + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              gate_in,
    input  logic [NUM_CH-1:0] ch_in,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              drop_err
);

    logic              gate_lvl;
    logic [NUM_CH-1:0] rise;
    logic [1:0]        push_n;
    logic [WORD_W-1:0] push_w0, push_w1;

    bit_sync #(.W(1)) u_gate_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (gate_in),
        .q_sync  (gate_lvl)
    );

    edge_catch #(.NUM_CH(NUM_CH)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_async (ch_in),
        .rise     (rise)
    );

    stamp_sequencer #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .gate_lvl (gate_lvl),
        .rise     (rise),
        .no_start (cfg[CFG_NO_START]),
        .no_end   (cfg[CFG_NO_END]),
        .push_n   (push_n),
        .push_w0  (push_w0),
        .push_w1  (push_w1)
    );

    word_queue #(.WORD_W(WORD_W), .DEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_n    (push_n),
        .push_w0   (push_w0),
        .push_w1   (push_w1),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .drop_err  (drop_err)
    );

    // R8: a full FIFO at an edge means no strobe in the next cycle
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> !fifo_wr);

    // R9: reset leaves the write port and error flag quiet
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!fifo_wr && !drop_err));

endmodule

// File: tb/gated_stamp_packer_tb.sv
module gated_stamp_packer_tb;

    localparam int NCH  = 8;
    localparam int TSW  = 24;
    localparam int WW   = NCH + TSW;
    localparam int STW  = 5;
    localparam int SWW  = NCH + STW;
    localparam int CAPN = 512;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b0;
    logic           gate_in = 1'b0;
    logic [NCH-1:0] ch_in = '0;
    logic [1:0]     cfg = 2'b00;
    logic           fifo_full = 1'b0;
    logic           fifo_wr, fifo_wr_s;
    logic [WW-1:0]  fifo_data;
    logic [SWW-1:0] fifo_data_s;
    logic           drop_err, drop_err_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [WW-1:0]  cap  [CAPN];
    logic [SWW-1:0] scap [CAPN];
    int ncap  = 0;
    int nscap = 0;

    always #2 clk = ~clk;

    gated_stamp_packer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
        .ch_in(ch_in), .cfg(cfg), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .drop_err(drop_err)
    );

    gated_stamp_packer #(.TS_W(STW)) u_dut_wrap (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
        .ch_in(ch_in), .cfg(cfg), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr_s), .fifo_data(fifo_data_s), .drop_err(drop_err_s)
    );

    // Record every written word away from the active edge
    always @(negedge clk) begin
        if (fifo_wr && ncap < CAPN) begin
            cap[ncap] = fifo_data;
            ncap++;
        end
        if (fifo_wr_s && nscap < CAPN) begin
            scap[nscap] = fifo_data_s;
            nscap++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        tick_en = 1'b1;
        step(1);
        tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic open_gate();
        gate_in = 1'b1;
        step(5);
    endtask

    task automatic close_gate();
        gate_in = 1'b0;
        step(5);
        tick();
        step(6);
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        step(4);
        rst_n = 1'b1;
        step(2);
        chk("R9 wr after reset", 64'(fifo_wr), 64'd0);
        chk("R9 err after reset", 64'(drop_err), 64'd0);
        step(6);
        chk("R9 no words while idle", 64'(ncap), 64'd0);
    endtask

    // R1 R2 R3 R10: basic packet with single and simultaneous edges
    task automatic t_basic();
        int b = ncap;
        open_gate();
        ch_in = 8'h01; step(5); tick();
        ch_in = 8'h00; step(5); tick(); tick();
        ch_in = 8'h03; step(5); tick();
        ch_in = 8'h00; step(5);
        close_gate();
        chk("R10 basic word count", 64'(ncap - b), 64'd4);
        chk("R2 start word", 64'(cap[b]), 64'h00000000);
        chk("R1 first event stamp", 64'(cap[b+1]), 64'h01000001);
        chk("R3 same-cycle merge", 64'(cap[b+2]), 64'h03000004);
        chk("R6 end word", 64'(cap[b+3]), 64'h00000005);
    endtask

    // R3: edges in different cycles of one tick period merge
    task automatic t_stagger();
        int b = ncap;
        open_gate();
        ch_in = 8'h80; step(3);
        ch_in = 8'h84; step(5); tick();
        ch_in = 8'h00; step(5); tick();
        close_gate();
        chk("R3 stagger word count", 64'(ncap - b), 64'd3);
        chk("R3 staggered merge", 64'(cap[b+1]), 64'h84000001);
        chk("R3 quiet tick no word", 64'(cap[b+2]), 64'h00000003);
    endtask

    // R4: edges outside the gate and in the closing window are ignored
    task automatic t_outside();
        int b = ncap;
        ch_in = 8'h20; step(5);
        ch_in = 8'h00; step(3); tick(); step(6);
        chk("R4 idle edge no word", 64'(ncap - b), 64'd0);
        open_gate();
        gate_in = 1'b0; step(5);
        ch_in = 8'h08; step(5); tick();
        ch_in = 8'h00; step(6);
        chk("R4 closing edge word count", 64'(ncap - b), 64'd2);
        chk("R4 closing edge end only", 64'(cap[b+1]), 64'h00000001);
    endtask

    // R2 R6: start and end suppression
    task automatic t_suppress();
        int b = ncap;
        cfg = 2'b10;
        open_gate();
        ch_in = 8'h02; step(5); tick();
        ch_in = 8'h00; step(5);
        close_gate();
        chk("R2 no start count", 64'(ncap - b), 64'd2);
        chk("R2 no start first word", 64'(cap[b]), 64'h02000001);
        chk("R2 no start end word", 64'(cap[b+1]), 64'h00000002);
        b = ncap;
        cfg = 2'b01;
        open_gate();
        ch_in = 8'h02; step(5); tick();
        ch_in = 8'h00; step(5);
        close_gate();
        chk("R6 no end count", 64'(ncap - b), 64'd2);
        chk("R6 no end last word", 64'(cap[b+1]), 64'h02000001);
        cfg = 2'b00;
    endtask

    // R6 R10: pending edge flushed before the end word on the same tick
    task automatic t_close_pending();
        int b = ncap;
        open_gate();
        ch_in = 8'h40; step(5);
        gate_in = 1'b0; step(5); tick();
        ch_in = 8'h00; step(6);
        chk("R6 pending count", 64'(ncap - b), 64'd3);
        chk("R10 pending event first", 64'(cap[b+1]), 64'h40000001);
        chk("R6 end after pending", 64'(cap[b+2]), 64'h00000001);
    endtask

    // R5: wrap with an event on the same tick (narrow instance)
    task automatic t_wrap();
        int b = ncap;
        int sb = nscap;
        open_gate();
        ticks(31);
        ch_in = 8'h10; step(5); tick();
        ch_in = 8'h00; step(5);
        close_gate();
        chk("R5 wrap word count", 64'(nscap - sb), 64'd4);
        chk("R5 overflow word", 64'(scap[sb+1]), 64'h001F);
        chk("R5 event after wrap", 64'(scap[sb+2]), 64'h0200);
        chk("R5 end after wrap", 64'(scap[sb+3]), 64'h0001);
        chk("R1 wide counter no wrap", 64'(cap[b+1]), 64'h10000020);
        chk("R1 wide counter end", 64'(cap[b+2]), 64'h00000021);
    endtask

    // R7: end word deferred when the closing tick wraps
    task automatic t_end_defer();
        int b = ncap;
        int sb = nscap;
        open_gate();
        ticks(31);
        gate_in = 1'b0; step(5); tick(); step(6);
        chk("R7 no end on wrap tick", 64'(nscap - sb), 64'd2);
        chk("R7 overflow on close", 64'(scap[sb+1]), 64'h001F);
        tick(); step(6);
        chk("R7 deferred end count", 64'(nscap - sb), 64'd3);
        chk("R7 deferred end stamp", 64'(scap[sb+2]), 64'h0001);
        chk("R7 wide end word", 64'(cap[b+1]), 64'h00000020);
        chk("R7 wide no extra word", 64'(ncap - b), 64'd2);
    endtask

    // R8 R9: full FIFO drops words, flag sticks until reset
    task automatic t_full();
        int b = ncap;
        fifo_full = 1'b1;
        open_gate();
        ch_in = 8'h01; step(5); tick();
        ch_in = 8'h00; step(5);
        close_gate();
        fifo_full = 1'b0;
        step(3);
        chk("R8 nothing written when full", 64'(ncap - b), 64'd0);
        chk("R8 error raised", 64'(drop_err), 64'd1);
        b = ncap;
        open_gate();
        close_gate();
        chk("R8 later packet count", 64'(ncap - b), 64'd2);
        chk("R8 later end word", 64'(cap[b+1]), 64'h00000001);
        chk("R8 error stays", 64'(drop_err), 64'd1);
        rst_n = 1'b0; step(3);
        rst_n = 1'b1; step(2);
        chk("R9 reset clears error", 64'(drop_err), 64'd0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stagger();
        t_outside();
        t_suppress();
        t_close_pending();
        t_wrap();
        t_end_defer();
        t_full();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule